// File: doc/BRIEF.md
# Multilane DDR Word Serializer

This block is the transmit-side lane logic of a source-synchronous link with four data lanes and one forwarded clock lane. A parallel word for every data lane is taken in through a valid/ready handshake. Each lane then shifts its word out most significant bit first at double data rate. Every unit interval (UI) carries one bit, and the forwarded clock toggles once per UI, so consecutive bits sit on alternating rising and falling clock edges. The word length is chosen at run time as 10, 12, 14 or 16 bits.

The design runs on a fast tick clock that divides every UI into eight ticks. Each data lane and the clock lane carry their own 3-bit skew code. A code delays that lane's serial stream by that many ticks, which is one eighth of a UI per step. This lets a board designer move clock and data edges relative to each other. Width and skew settings are captured together with each word, so software may rewrite them at any time without harming the word currently on the wires.

Top module: `ddr_lane_serializer`

## Requirements
- R1: While `rst` is high and in the first tick after it falls, `lane_out` is all zero, `clk_out` is 0 and `word_ready` is 0. Every skew code resets to 0.
- R2: `width_sel` encodes the word length: 0 gives 10 bits, 1 gives 12, 2 gives 14 and 3 gives 16. Lane k takes its word right-justified from `word_data[16k+15:16k]`. Bits above the selected length are never transmitted.
- R3: Each word leaves MSB first. Every bit holds for one UI of 8 ticks. `clk_out` toggles once per UI, at the middle of each bit, and the first bit of every word is centred on a rising edge.
- R4: With lane skew code d, bit i of a word accepted in tick n appears on that lane in ticks n+2+8i+d through n+9+8i+d. Tick n is the tick in which `word_valid` and `word_ready` are both high.
- R5: `word_ready` is high for only one tick per UI, the last tick. During a word it is high only in the word's final UI. While idle it is high once every two UIs. Back-to-back words follow each other with no gap: the next acceptance comes 8×length ticks after the previous one.
- R6: With no word in progress every data lane drives 0, and `clk_out` keeps toggling every UI.
- R7: Width and skew inputs are sampled only at acceptance. Changing them in the middle of a word leaves that word intact. A new skew code takes effect at the midpoint of the first UI of the word that carried it.
- R8: The clock skew code dc delays `clk_out` by dc ticks. For a word accepted in tick n, `clk_out` is 0 in tick n+5+dc and 1 in tick n+6+dc.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, eight ticks per UI |
| rst | input | 1 | Synchronous active-high reset |
| width_sel | input | 2 | Word length select, sampled at acceptance |
| word_valid | input | 1 | A word for all lanes is offered |
| word_ready | output | 1 | The block accepts a word this tick |
| word_data | input | 64 | Four 16-bit lane words, lane 0 lowest |
| lane_skew | input | 12 | Four 3-bit data lane skew codes, lane 0 lowest |
| clk_skew | input | 3 | Skew code of the forwarded clock |
| lane_out | output | 4 | Serial data lanes |
| clk_out | output | 1 | Forwarded DDR clock |

## Verification
The bench records every tick of the lanes and the clock, then rebuilds each word by sampling the centre of each UI at that lane's own skew. A wrong bit order or a wrong length mask shows up as a corrupted word, and a delay line that is one tick off breaks the check on the first and last tick of each interior bit. Streams in which width and skew codes change between every pair of words test boundary capture: a design that applied settings at once would garble the tail of the previous word or mis-time the head of the next. The idle windows count `word_ready` pulses and clock toggles, and they confirm that the lanes are quiet, which exposes a lost clock or a stale final bit.

// File: rtl/ddrser_pkg.sv
package ddrser_pkg;

    localparam int unsigned WORD_MAX = 16;
    localparam int unsigned CNT_W    = $clog2(WORD_MAX);

    typedef enum logic [1:0] {
        WSEL_10 = 2'd0,
        WSEL_12 = 2'd1,
        WSEL_14 = 2'd2,
        WSEL_16 = 2'd3
    } wsel_e;

    typedef logic [CNT_W-1:0] bitcnt_t;

    typedef struct packed {
        logic    busy;
        bitcnt_t idx;
        bitcnt_t last_idx;
    } seq_t;

    // index of the final bit for a given length select
    function automatic bitcnt_t last_index(input wsel_e s);
        return CNT_W'(WORD_MAX - 1 - 2 * (3 - int'(s)));
    endfunction

    // move a right-justified word so its top bit sits at WORD_MAX-1
    function automatic logic [WORD_MAX-1:0] align_msb(input logic [WORD_MAX-1:0] w,
                                                      input wsel_e s);
        return w << (WORD_MAX - 1 - int'(last_index(s)));
    endfunction

endpackage

// File: rtl/phase_gen.sv
module phase_gen #(
    parameter int unsigned PH_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] ph,
    output logic            ui_odd,
    output logic            fclk_raw
);
    localparam int unsigned HALF = 2 ** (PH_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph       <= '0;
            ui_odd   <= 1'b0;
            fclk_raw <= 1'b0;
        end else begin
            ph <= ph + 1'b1;
            if (ph == {PH_W{1'b1}})
                ui_odd <= ~ui_odd;
            if (ph == PH_W'(HALF - 1))
                fclk_raw <= ~fclk_raw;
        end
    end
endmodule

// File: rtl/word_shift.sv
module word_shift
    import ddrser_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                step,
    input  logic [WORD_MAX-1:0] word_in,
    input  wsel_e               wsel,
    output logic                msb
);
    logic [WORD_MAX-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)
            sr <= '0;
        else if (load)
            sr <= align_msb(word_in, wsel);
        else if (step)
            sr <= sr << 1;
    end

    assign msb = sr[WORD_MAX-1];
endmodule

// File: rtl/tap_delay.sv
module tap_delay #(
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic [SEL_W-1:0] sel,
    output logic             dout
);
    localparam int unsigned TAPS = 2 ** SEL_W;

    logic [TAPS-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst)
            pipe <= '0;
        else
            pipe <= {pipe[TAPS-2:0], din};
    end

    assign dout = pipe[sel];
endmodule

// File: rtl/ddr_lane_serializer.sv
module ddr_lane_serializer
    import ddrser_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned DLY_W = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                width_sel,
    input  logic                      word_valid,
    output logic                      word_ready,
    input  logic [LANES*WORD_MAX-1:0] word_data,
    input  logic [LANES*DLY_W-1:0]    lane_skew,
    input  logic [DLY_W-1:0]          clk_skew,
    output logic [LANES-1:0]          lane_out,
    output logic                      clk_out
);
    localparam int unsigned NSLOT = LANES + 1;
    localparam int unsigned HALF  = (2 ** DLY_W) / 2;

    logic [DLY_W-1:0] ph;
    logic             ui_odd;
    logic             fclk_raw;
    seq_t             seq;
    logic             ui_end;
    logic             at_last;
    logic             fire;
    logic             step;
    logic [LANES-1:0] msb;
    logic [LANES-1:0] raw;

    logic [NSLOT-1:0][DLY_W-1:0] skew_pend;
    logic [NSLOT-1:0][DLY_W-1:0] skew_act;

    phase_gen #(.PH_W(DLY_W)) u_phase (
        .clk      (clk),
        .rst      (rst),
        .ph       (ph),
        .ui_odd   (ui_odd),
        .fclk_raw (fclk_raw)
    );

    assign ui_end     = (ph == {DLY_W{1'b1}});
    assign at_last    = (seq.idx == seq.last_idx);
    assign word_ready = ui_end & (seq.busy ? at_last : ui_odd);
    assign fire       = word_valid & word_ready;
    assign step       = ui_end & seq.busy & ~at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            seq <= '0;
        end else if (fire) begin
            seq.busy     <= 1'b1;
            seq.idx      <= '0;
            seq.last_idx <= last_index(wsel_e'(width_sel));
        end else if (ui_end && seq.busy) begin
            if (at_last)
                seq.busy <= 1'b0;
            else
                seq.idx <= seq.idx + 1'b1;
        end
    end

    // skew codes: captured with the word, switched in at mid-UI
    always_ff @(posedge clk) begin
        if (rst) begin
            skew_pend <= '0;
            skew_act  <= '0;
        end else begin
            if (fire)
                skew_pend <= {clk_skew, lane_skew};
            if (ph == DLY_W'(HALF))
                skew_act <= skew_pend;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        word_shift u_shift (
            .clk     (clk),
            .rst     (rst),
            .load    (fire),
            .step    (step),
            .word_in (word_data[l*WORD_MAX +: WORD_MAX]),
            .wsel    (wsel_e'(width_sel)),
            .msb     (msb[l])
        );

        assign raw[l] = seq.busy & msb[l];

        tap_delay #(.SEL_W(DLY_W)) u_tap (
            .clk  (clk),
            .rst  (rst),
            .din  (raw[l]),
            .sel  (skew_act[l]),
            .dout (lane_out[l])
        );
    end

    tap_delay #(.SEL_W(DLY_W)) u_clk_tap (
        .clk  (clk),
        .rst  (rst),
        .din  (fclk_raw),
        .sel  (skew_act[LANES]),
        .dout (clk_out)
    );
endmodule

// File: rtl/ddr_lane_serializer_chk.sv
module ddr_lane_serializer_chk
    import ddrser_pkg::*;
#(
    parameter int unsigned LANES = 4,
    parameter int unsigned DLY_W = 3
) (
    input logic                         clk,
    input logic                         rst,
    input logic [DLY_W-1:0]             ph,
    input logic                         busy,
    input logic [CNT_W-1:0]             idx,
    input logic [CNT_W-1:0]             last_idx,
    input logic                         word_valid,
    input logic                         word_ready,
    input logic                         fclk_raw,
    input logic [(LANES+1)*DLY_W-1:0]   skew_act,
    input logic [LANES-1:0]             lane_out
);
    localparam int unsigned TICKS = 2 ** DLY_W;
    localparam int unsigned HALF  = TICKS / 2;

    logic [DLY_W+1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst || busy)
            idle_cnt <= '0;
        else if (idle_cnt != (DLY_W+2)'(TICKS))
            idle_cnt <= idle_cnt + 1'b1;
    end

    AST_READY_SLOT: assert property (@(posedge clk) disable iff (rst)
        word_ready |-> ph == {DLY_W{1'b1}}); // R5

    AST_READY_WORD_END: assert property (@(posedge clk) disable iff (rst)
        (word_ready && busy) |-> idx == last_idx); // R5

    AST_INDEX_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy |-> idx <= last_idx); // R2

    AST_LENGTH_HELD: assert property (@(posedge clk) disable iff (rst)
        !(word_valid && word_ready) |=> $stable(last_idx)); // R7

    AST_SKEW_MID_UI: assert property (@(posedge clk) disable iff (rst)
        !$stable(skew_act) |-> $past(ph) == DLY_W'(HALF)); // R7

    AST_FCLK_MID_UI: assert property (@(posedge clk) disable iff (rst)
        !$stable(fclk_raw) |-> $past(ph) == DLY_W'(HALF - 1)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (idle_cnt == (DLY_W+2)'(TICKS)) |-> lane_out == '0); // R6
endmodule

bind ddr_lane_serializer ddr_lane_serializer_chk #(
    .LANES (LANES),
    .DLY_W (DLY_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ph         (ph),
    .busy       (seq.busy),
    .idx        (seq.idx),
    .last_idx   (seq.last_idx),
    .word_valid (word_valid),
    .word_ready (word_ready),
    .fclk_raw   (fclk_raw),
    .skew_act   (skew_act),
    .lane_out   (lane_out)
);

// File: tb/ddr_lane_serializer_test.sv
`timescale 1ns/1ps
module ddr_lane_serializer_test;

    localparam int DEPTH = 8192;
    localparam int MAXW  = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  width_sel = 2'd0;
    logic        word_valid = 1'b0;
    logic        word_ready;
    logic [63:0] word_data = '0;
    logic [11:0] lane_skew = '0;
    logic [2:0]  clk_skew = '0;
    logic [3:0]  lane_out;
    logic        clk_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    logic [3:0] trc_lane [0:DEPTH-1];
    logic       trc_clk  [0:DEPTH-1];

    logic [63:0] w_data [0:MAXW-1];
    int          w_n    [0:MAXW-1];
    logic [1:0]  w_ws   [0:MAXW-1];
    logic [11:0] w_sk   [0:MAXW-1];
    logic [2:0]  w_ck   [0:MAXW-1];
    int          nw = 0;

    ddr_lane_serializer uut (
        .clk        (clk),
        .rst        (rst),
        .width_sel  (width_sel),
        .word_valid (word_valid),
        .word_ready (word_ready),
        .word_data  (word_data),
        .lane_skew  (lane_skew),
        .clk_skew   (clk_skew),
        .lane_out   (lane_out),
        .clk_out    (clk_out)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        if (!rst && cyc < DEPTH) begin
            trc_lane[cyc] = lane_out;
            trc_clk[cyc]  = clk_out;
        end
    end

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // offer one word; returns after the accepting edge plus a small offset
    task automatic send_word(input logic [63:0] d, input logic [1:0] ws,
                             input logic [11:0] sk, input logic [2:0] ck);
        word_data  = d;
        width_sel  = ws;
        lane_skew  = sk;
        clk_skew   = ck;
        word_valid = 1'b1;
        do @(negedge clk); while (!word_ready);
        w_data[nw] = d; w_ws[nw] = ws; w_sk[nw] = sk; w_ck[nw] = ck; w_n[nw] = cyc;
        nw++;
        @(posedge clk); #1;
        // scramble the settings mid-word; the accepted word must not notice
        width_sel = ~ws;
        lane_skew = ~sk;
        clk_skew  = ~ck;
        word_data = ~d;
    endtask

    task automatic end_stream();
        word_valid = 1'b0;
        repeat (8 * 16 + 24) @(posedge clk);
        #1;
    endtask

    task automatic verify(input int first, input int last, input string tag);
        for (int k = first; k <= last; k++) begin
            int n = w_n[k];
            int w = 10 + 2 * int'(w_ws[k]);
            int dc = int'(w_ck[k]);
            if (k < last)
                check("R5 back-to-back spacing", 64'(w_n[k+1] - n), 64'(8 * w));
            check("R8 clock low before first bit", 64'(trc_clk[n+5+dc]), 64'd0);
            check("R8 clock rises on first bit", 64'(trc_clk[n+6+dc]), 64'd1);
            for (int l = 0; l < 4; l++) begin
                int d = int'(w_sk[k][3*l +: 3]);
                logic [63:0] got = '0;
                logic [63:0] exp = 64'(w_data[k][16*l +: 16]) & ((64'd1 << w) - 1);
                int edge_bad = 0;
                for (int i = 0; i < w; i++) begin
                    logic b = trc_lane[n+6+8*i+d][l];
                    got = {got[62:0], b};
                    if (i >= 1 && i <= w - 2) begin
                        if (trc_lane[n+2+8*i+d][l] !== b || trc_lane[n+9+8*i+d][l] !== b)
                            edge_bad++;
                    end
                end
                check(tag, got, exp);
                check("R4 bit holds its full UI at its skew", 64'(edge_bad), 64'd0);
            end
        end
    endtask

    task automatic test_reset();
        check("R1 lanes in reset", 64'(lane_out), 64'd0);
        check("R1 clock in reset", 64'(clk_out), 64'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 lanes after reset", 64'(lane_out), 64'd0);
        check("R1 clock after reset", 64'(clk_out), 64'd0);
        check("R1 ready after reset", 64'(word_ready), 64'd0);
        @(posedge clk); #1;
    endtask

    task automatic test_msb_order();
        int s = nw;
        send_word({16'h8001, 16'hC003, 16'h0001, 16'h8000}, 2'd3, 12'h000, 3'd0);
        end_stream();
        verify(s, nw - 1, "R3 MSB-first order");
    endtask

    task automatic test_widths();
        int s = nw;
        for (int k = 0; k < 8; k++)
            send_word({$urandom, $urandom}, 2'(k % 4), 12'h000, 3'd0);
        end_stream();
        verify(s, nw - 1, "R2 word per width");
    endtask

    task automatic test_skew();
        int s = nw;
        send_word({$urandom, $urandom}, 2'd3, {3'd7, 3'd5, 3'd3, 3'd1}, 3'd2);
        send_word({$urandom, $urandom}, 2'd3, {3'd7, 3'd5, 3'd3, 3'd1}, 3'd2);
        send_word({$urandom, $urandom}, 2'd0, {3'd2, 3'd4, 3'd0, 3'd7}, 3'd6);
        send_word({$urandom, $urandom}, 2'd0, {3'd2, 3'd4, 3'd0, 3'd7}, 3'd7);
        end_stream();
        verify(s, nw - 1, "R4 lane skew");
    endtask

    task automatic test_midword_change();
        int s = nw;
        for (int k = 0; k < 10; k++)
            send_word({$urandom, $urandom}, 2'(3 - (k % 4)),
                      {3'(k), 3'(7 - k), 3'(3 * k), 3'(k + 2)}, 3'(5 * k));
        end_stream();
        verify(s, nw - 1, "R7 settings held through word");
    endtask

    task automatic test_idle();
        int rdy = 0;
        int tog = 0;
        int busy_lane = 0;
        logic prev;
        word_valid = 1'b0;
        repeat (40) @(posedge clk);
        @(negedge clk);
        prev = clk_out;
        for (int t = 0; t < 64; t++) begin
            @(negedge clk);
            if (word_ready) rdy++;
            if (clk_out !== prev) tog++;
            if (lane_out !== 4'd0) busy_lane++;
            prev = clk_out;
        end
        check("R6 lanes quiet while idle", 64'(busy_lane), 64'd0);
        check("R6 clock runs while idle", 64'(tog), 64'd8);
        check("R5 idle ready pulses", 64'(rdy), 64'd4);
        @(posedge clk); #1;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        test_reset();
        test_idle();
        test_msb_order();
        test_widths();
        test_skew();
        test_midword_change();
        test_idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule